// File: doc/BRIEF.md
# Bounded Up-Counting Timer Array

A bank of general-purpose timers, clocked by the system bus clock and reached through a flat word-addressed register port. Each channel has three software-visible settings: an enable, a start value and an end value. While enabled, a channel counts up by one per clock from its start value. When it reaches its end value, it reloads the start value on the next clock and keeps running. That reload sets a sticky per-channel pending bit. A channel that repeats every N clocks is therefore programmed with an end value that is N−1 above its start value.

Pending bits are kept apart from the interrupt mask. A single level interrupt output is high whenever a pending bit is set and its mask bit is also set. Masking a channel therefore never discards an event; it only hides it from the output. One channel, chosen by parameter, is the event timer. Its end value is only 30 bits wide. Any other channel programmed from start 0 to end 0xFFFFFFFF serves as a free-running 32-bit counter that software can read at any moment.

Writing a channel's end value also restarts that channel from its start value on the same clock. This lets software arm a new interval in one access.

Top module: `tmr_array`

## Requirements
- R1: An active reset clears every enable, start value, end value, count, pending bit and mask bit, and holds the interrupt low. Registers at word addresses 19 to 31 read as zero.
- R2: Channel c uses word addresses 4c+0 (enable, bit 0), 4c+1 (start value), 4c+2 (end value) and 4c+3 (count, read-only). While enabled, the count rises by one per clock. On the clock after it equals the end value, it reloads the start value.
- R3: A write to a channel's end value loads that channel's count with its start value at the same clock edge, whether or not the channel is enabled.
- R4: The event channel (index 1) keeps only bits 29:0 of a written end value and reads the upper bits as zero. All other channels keep all 32 bits.
- R5: Pending bit c of the status register (word address 16) sets on the clock after channel c, while enabled, holds a count equal to its end value. The bit then stays set until it is cleared.
- R6: Writing a word to address 17, or to the status address 16, clears each pending bit whose position holds a 1 and leaves the others. Address 17 reads as zero.
- R7: When a channel's reload and a clear of its pending bit fall on the same clock, the bit ends up set.
- R8: The interrupt output is high exactly when some pending bit and the same bit of the mask register (word address 18) are both 1. Writing the mask leaves the pending bits unchanged.
- R9: With enable bit 0 cleared, a channel's count holds its value.
- R10: Writes to a count address are ignored. With start 0 and end 0xFFFFFFFF, a channel reads as a free-running counter whose value grows by exactly the number of clocks between two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Combined level interrupt |

## Verification
The main timing path is exercised with four channel set-ups:
- A short periodic window from 5 to 8 tells an off-by-one in the reload from a correct period.
- A four-clock window starting at 0 is timed so that a clear lands on the reload clock, which separates set priority from clear priority.
- A free-running full-range channel shows that the count advances one per clock while it is read.
- The event channel, given an all-ones end value, separates 30-bit truncation from full-width storage.

A behavioural model of the whole register file is stepped alongside the design. It is compared on every clock at whatever address is being presented, so the reload-on-write, hold and mask cases are checked at the exact cycle they take effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // per-channel register slot (addr[1:0])
  localparam logic [1:0] SLOT_ENABLE = 2'd0;
  localparam logic [1:0] SLOT_START  = 2'd1;
  localparam logic [1:0] SLOT_END    = 2'd2;
  localparam logic [1:0] SLOT_COUNT  = 2'd3;

  // global register slot (addr[1:0] inside the global region)
  localparam logic [1:0] GSLOT_PEND  = 2'd0;
  localparam logic [1:0] GSLOT_ACK   = 2'd1;
  localparam logic [1:0] GSLOT_MASK  = 2'd2;

  typedef struct packed {
    logic enable;
    logic start;
    logic stop;
  } chan_wr_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HIGH_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_wr_t         wr_sel,
  input  logic [CNT_W-1:0] wdata,
  output logic             en_o,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] stop_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] STOP_KEEP = {CNT_W{1'b1}} >> (CNT_W - HIGH_W);

  logic             en_q, en_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] stop_q, stop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             hit;

  assign hit = en_q && (cnt_q == stop_q);

  // next-state logic
  always_comb begin
    en_d    = wr_sel.enable ? wdata[0] : en_q;
    start_d = wr_sel.start  ? wdata : start_q;
    stop_d  = wr_sel.stop   ? (wdata & STOP_KEEP) : stop_q;
    cnt_ce  = wr_sel.stop || en_q;
    if (wr_sel.stop || hit) cnt_d = start_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= '0;
      stop_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_sel.enable) en_q    <= en_d;
      if (wr_sel.start)  start_q <= start_d;
      if (wr_sel.stop)   stop_q  <= stop_d;
      if (cnt_ce)        cnt_q   <= cnt_d;
    end
  end

  assign en_o     = en_q;
  assign start_o  = start_q;
  assign stop_o   = stop_q;
  assign count_o  = cnt_q;
  assign expire_o = hit;

  // R3
  end_write_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel.stop |=> cnt_q == $past(start_q));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !hit && !wr_sel.stop) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_sel.stop) |=> cnt_q == $past(start_q));
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_sel.stop) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int N_TMR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] expire,
  input  logic             ack_wr,
  input  logic             mask_wr,
  input  logic [N_TMR-1:0] wdata,
  output logic [N_TMR-1:0] pend_o,
  output logic [N_TMR-1:0] mask_o,
  output logic             irq_o
);
  logic [N_TMR-1:0] pend_q, pend_d;
  logic [N_TMR-1:0] mask_q;
  logic [N_TMR-1:0] ack_bits;

  // next-state logic: set has priority over acknowledge
  always_comb begin
    ack_bits = ack_wr ? wdata : '0;
    pend_d   = (pend_q & ~ack_bits) | expire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_wr) mask_q <= wdata;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);

  // R7
  set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> (pend_q & $past(expire)) == $past(expire));
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> (pend_q & $past(wdata & ~expire)) == '0);
  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> (pend_q & $past(pend_q)) == $past(pend_q));
  // R8
  mask_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !ack_wr && expire == '0) |=> pend_q == $past(pend_q));
endmodule

// File: rtl/tmr_array.sv
module tmr_array
  import tmr_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int CNT_W   = 32,
  parameter int EVT_IDX = 1,
  parameter int EVT_W   = 30,
  localparam int SEL_W  = $clog2(N_TMR),
  localparam int ADDR_W = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic             srst_n;
  logic             in_glb;
  logic [SEL_W-1:0] sel;
  logic [1:0]       slot;
  logic             glb_hit;
  logic             ack_wr;
  logic             mask_wr;

  logic [N_TMR-1:0] ch_en;
  logic [N_TMR-1:0] ch_expire;
  logic [CNT_W-1:0] ch_start [N_TMR];
  logic [CNT_W-1:0] ch_stop  [N_TMR];
  logic [CNT_W-1:0] ch_count [N_TMR];
  logic [N_TMR-1:0] pend;
  logic [N_TMR-1:0] mask;

  tmr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (srst_n)
  );

  assign in_glb  = addr[ADDR_W-1];
  assign sel     = addr[ADDR_W-2:2];
  assign slot    = addr[1:0];
  assign glb_hit = in_glb && (sel == '0);
  assign ack_wr  = wr_en && glb_hit && (slot == GSLOT_PEND || slot == GSLOT_ACK);
  assign mask_wr = wr_en && glb_hit && (slot == GSLOT_MASK);

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    localparam int HW = (i == EVT_IDX) ? EVT_W : CNT_W;
    chan_wr_t wsel;
    logic     hit_ch;

    assign hit_ch      = wr_en && !in_glb && (sel == SEL_W'(i));
    assign wsel.enable = hit_ch && (slot == SLOT_ENABLE);
    assign wsel.start  = hit_ch && (slot == SLOT_START);
    assign wsel.stop   = hit_ch && (slot == SLOT_END);

    tmr_channel #(
      .CNT_W  (CNT_W),
      .HIGH_W (HW)
    ) u_ch (
      .clk      (clk),
      .rst_n    (srst_n),
      .wr_sel   (wsel),
      .wdata    (wdata),
      .en_o     (ch_en[i]),
      .start_o  (ch_start[i]),
      .stop_o   (ch_stop[i]),
      .count_o  (ch_count[i]),
      .expire_o (ch_expire[i])
    );
  end

  tmr_irq_unit #(
    .N_TMR (N_TMR)
  ) u_irq (
    .clk     (clk),
    .rst_n   (srst_n),
    .expire  (ch_expire),
    .ack_wr  (ack_wr),
    .mask_wr (mask_wr),
    .wdata   (wdata[N_TMR-1:0]),
    .pend_o  (pend),
    .mask_o  (mask),
    .irq_o   (irq)
  );

  // read mux
  always_comb begin
    rdata = '0;
    if (in_glb) begin
      if (glb_hit) begin
        case (slot)
          GSLOT_PEND: rdata[N_TMR-1:0] = pend;
          GSLOT_MASK: rdata[N_TMR-1:0] = mask;
          default:    rdata = '0;
        endcase
      end
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (sel == SEL_W'(i)) begin
          case (slot)
            SLOT_ENABLE: rdata[0] = ch_en[i];
            SLOT_START:  rdata    = ch_start[i];
            SLOT_END:    rdata    = ch_stop[i];
            default:     rdata    = ch_count[i];
          endcase
        end
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |=> (pend == '0 && mask == '0 && !irq));
  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> ((pend & mask) != '0));
endmodule

// File: tb/tmr_array_bench.sv
module tmr_array_bench;
  localparam int N  = 4;
  localparam int EV = 1;
  localparam int TP = 20;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks;
  int errors;
  bit done;

  tmr_array u_tmr_array (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #(TP/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_cnt [N];
  logic [31:0] m_lo  [N];
  logic [31:0] m_hi  [N];
  logic        m_en  [N];
  logic [3:0]  m_st;
  logic [3:0]  m_mk;
  int          m_rs;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    int c;
    c = int'(a[3:2]);
    if (a[4]) begin
      if (a[3:2] != 2'd0) return 32'd0;
      if (a[1:0] == 2'd0) return {28'd0, m_st};
      if (a[1:0] == 2'd2) return {28'd0, m_mk};
      return 32'd0;
    end
    case (a[1:0])
      2'd0:    return {31'd0, m_en[c]};
      2'd1:    return m_lo[c];
      2'd2:    return m_hi[c];
      default: return m_cnt[c];
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a[4]) begin
      if (a[1:0] == 2'd0) return "R5";
      if (a[1:0] == 2'd1) return "R6";
      if (a[1:0] == 2'd2) return "R8";
      return "R1";
    end
    if (a[1:0] == 2'd3) return "R2";
    if (a[1:0] == 2'd2) return "R4";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic m_step();
    logic [3:0] fired;
    logic [3:0] ack;
    if (!rst_n || m_rs < 2) begin
      if (!rst_n) m_rs = 0; else m_rs++;
      for (int c = 0; c < N; c++) begin
        m_cnt[c] = '0; m_lo[c] = '0; m_hi[c] = '0; m_en[c] = 1'b0;
      end
      m_st = '0; m_mk = '0;
      return;
    end
    fired = '0;
    for (int c = 0; c < N; c++)
      if (m_en[c] && m_cnt[c] == m_hi[c]) fired[c] = 1'b1;
    ack = (wr_en && addr[4] && addr[3:2] == 2'd0 && addr[1:0] <= 2'd1) ? wdata[3:0] : 4'd0;
    for (int c = 0; c < N; c++) begin
      bool_upd(c, fired[c]);
    end
    m_st = (m_st & ~ack) | fired;
    if (wr_en && addr == 5'd18) m_mk = wdata[3:0];
  endtask

  task automatic bool_upd(input int c, input logic f);
    logic mine;
    mine = wr_en && !addr[4] && int'(addr[3:2]) == c;
    if (mine && addr[1:0] == 2'd2) m_cnt[c] = m_lo[c];
    else if (m_en[c]) m_cnt[c] = f ? m_lo[c] : m_cnt[c] + 32'd1;
    if (mine && addr[1:0] == 2'd0) m_en[c] = wdata[0];
    if (mine && addr[1:0] == 2'd1) m_lo[c] = wdata;
    if (mine && addr[1:0] == 2'd2) m_hi[c] = (c == EV) ? (wdata & 32'h3FFF_FFFF) : wdata;
  endtask

  // step model on each edge, compare a quarter period later
  always @(posedge clk) begin
    m_step();
    #(TP/4);
    if (!done) begin
      chk("R8", {31'd0, irq}, {31'd0, |(m_st & m_mk)});
      chk(tag_of(addr), rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    #(TP * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, b0;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'd0, v);  chk("R1", v, 32'd0);
    rd(5'd10, v); chk("R1", v, 32'd0);
    rd(5'd16, v); chk("R1", v, 32'd0);
    rd(5'd18, v); chk("R1", v, 32'd0);
    rd(5'd25, v); chk("R1", v, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);

    // R2 periodic window 5..8 on channel 0
    wr(5'd1, 32'd5);
    wr(5'd2, 32'd8);
    wr(5'd0, 32'd1);
    rd(5'd3, v); chk("R2", v, 32'd5);
    @(negedge clk);
    rd(5'd3, v); chk("R2", v, 32'd6);
    repeat (6) @(negedge clk);
    rd(5'd16, v); chk("R5", v & 32'd1, 32'd1);

    // R3 end write restarts from start
    wr(5'd2, 32'd100);
    rd(5'd3, v); chk("R3", v, 32'd5);

    // R9 disable holds
    wr(5'd0, 32'd0);
    rd(5'd3, a0);
    repeat (3) @(negedge clk);
    rd(5'd3, b0); chk("R9", b0, a0);

    // R10 count address not writable
    wr(5'd3, 32'd123);
    rd(5'd3, v); chk("R10", v, a0);

    // R4 event channel width
    wr(5'd6, 32'hFFFF_FFFF);
    rd(5'd6, v); chk("R4", v, 32'h3FFF_FFFF);
    wr(5'd2, 32'hFFFF_FFFF);
    rd(5'd2, v); chk("R4", v, 32'hFFFF_FFFF);

    // R10 free-running channel 3
    wr(5'd13, 32'd0);
    wr(5'd14, 32'hFFFF_FFFF);
    wr(5'd12, 32'd1);
    rd(5'd15, a0);
    repeat (10) @(negedge clk);
    rd(5'd15, b0); chk("R10", b0 - a0, 32'd10);

    // R6 acknowledge through the clear address
    wr(5'd17, 32'd1);
    rd(5'd16, v); chk("R6", v & 32'd1, 32'd0);
    rd(5'd17, v); chk("R6", v, 32'd0);

    // R7 acknowledge on the reload clock of channel 2 (window 0..3)
    wr(5'd9, 32'd0);
    wr(5'd10, 32'd3);
    wr(5'd8, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rd(5'd11, v);
      if (v == 32'd3) begin
        wr(5'd17, 32'd4);
        break;
      end
      @(negedge clk);
    end
    rd(5'd16, v); chk("R7", v & 32'd4, 32'd4);

    // R8 mask gates irq, pending survives
    wr(5'd18, 32'd4);
    chk("R8", {31'd0, irq}, 32'd1);
    wr(5'd18, 32'd0);
    chk("R8", {31'd0, irq}, 32'd0);
    rd(5'd16, v); chk("R8", v & 32'd4, 32'd4);

    // R6 one-hot write to the status address clears
    wr(5'd8, 32'd0);
    wr(5'd16, 32'd4);
    rd(5'd16, v); chk("R6", v & 32'd4, 32'd0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule